// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds the instructions waiting to execute in an out-of-order core that renames registers onto reorder-buffer entries. There is exactly one station for each functional-unit class: integer ALU, load, store and two floating-point units. Each station keeps an opcode, the reorder-buffer entry number that will receive its result, and two source operands. An operand either holds a value or waits on a reorder-buffer tag. Tag zero means "no producer, the architectural register file is current".

At dispatch the rename stage supplies a tag and a ready-in-buffer flag for each source. It also supplies the register-file value and the reorder-buffer value for that source. The station picks one of three sources for each operand. It takes the register-file value when the tag is zero. It takes the buffered value when the tag is nonzero and marked ready. Otherwise it stores the tag and waits. Completing functional units compete for a single result bus through a fixed-priority arbiter. Every waiting operand snoops the winning tag and value. A station requests issue once both operands hold values, and it frees itself after the grant. A flush empties every station.

Top module: `rs_array`

## Requirements
- R1: After reset every station is free and `issue_req_o` is all zero.
- R2: Class codes map to stations as follows: 0 is ALU, 1 is load, 2 is store, 3 is floating-point 0 and 4 is floating-point 1. `disp_stall_o` is high in the same cycle exactly when `disp_valid_i` is high and the addressed station is busy, or when the class code is 5 to 7. The state of other stations has no effect on it. An accepted dispatch stores the opcode and sets the station's `issue_tag_o` to `disp_dst_tag_i`.
- R3: A source whose rename tag is zero takes its value from `disp_rf_val_i`.
- R4: A source whose rename tag is nonzero and whose ready flag is set takes its value from `disp_rob_val_i`.
- R5: A source whose rename tag is nonzero and whose ready flag is clear stores the tag. It captures `cdb_val_o` in the first cycle that `cdb_valid_o` is high with `cdb_tag_o` equal to that tag. A bus result with any other tag leaves it waiting.
- R6: A waiting source whose tag equals the bus tag in the very cycle of its dispatch captures that bus value.
- R7: `issue_req_o[i]` is high exactly when station i is busy and both of its operands hold values. While it is high, `issue_v1_o[i]` and `issue_v2_o[i]` carry those values.
- R8: A station that sees `issue_gnt_i[i]` while requesting is free from the next cycle. A grant bit for a station that is not requesting has no effect.
- R9: Only one result is driven per cycle. `cdb_valid_o` is high when any `fu_done_i` bit is high, and `cdb_tag_o`/`cdb_val_o` carry the winning unit's tag and value. Every other done unit sees `fu_stall_o` high.
- R10: The lower unit index always wins the result bus: ALU first, then load, store, floating-point 0 and floating-point 1.
- R11: `flush_i` frees every station at the next edge and discards any dispatch presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Precise-state flush, clears all stations |
| disp_valid_i | input | 1 | Dispatch request |
| disp_class_i | input | 3 | Functional-unit class of the dispatched instruction |
| disp_op_i | input | OP_W | Opcode |
| disp_dst_tag_i | input | TAG_W | Reorder-buffer entry assigned to the instruction |
| disp_src_tag_i | input | 2xTAG_W | Rename tag per source |
| disp_src_rdy_i | input | 2 | Ready-in-buffer flag per source |
| disp_rf_val_i | input | 2xDATA_W | Register-file value per source |
| disp_rob_val_i | input | 2xDATA_W | Reorder-buffer value per source |
| disp_stall_o | output | 1 | Dispatch refused this cycle |
| issue_req_o | output | 5 | Station ready to issue |
| issue_gnt_i | input | 5 | Issue grant per station |
| issue_op_o | output | 5xOP_W | Opcode per station |
| issue_tag_o | output | 5xTAG_W | Destination tag per station |
| issue_v1_o | output | 5xDATA_W | First operand per station |
| issue_v2_o | output | 5xDATA_W | Second operand per station |
| fu_done_i | input | 5 | Functional unit has a result |
| fu_tag_i | input | 5xTAG_W | Result tag per unit |
| fu_val_i | input | 5xDATA_W | Result value per unit |
| fu_stall_o | output | 5 | Unit lost arbitration and must hold its result |
| cdb_valid_o | output | 1 | Result bus valid |
| cdb_tag_o | output | TAG_W | Result bus tag |
| cdb_val_o | output | DATA_W | Result bus value |

## Verification
The assertions assume that the dispatch class is in range whenever the station-tag check applies. They also assume that the issue logic may raise grant bits freely, because grants to idle stations must be harmless. Tag zero is never used as a pending tag, since the rename stage produces zero only for register-file sources. The random stimulus draws nonzero pending tags and bus tags from a small shared pool of seven, so tag hits are frequent. It mixes in invalid class codes, grants to idle stations and rare flushes. Directed cycles cover the three operand sources, a bus hit in the dispatch cycle and all units finishing together.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned NUM_RS = 5;
  localparam int unsigned CLS_W  = 3;
  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 3'd0,
    CLS_LD  = 3'd1,
    CLS_ST  = 3'd2,
    CLS_FP0 = 3'd3,
    CLS_FP1 = 3'd4
  } fu_cls_e;
endpackage

// File: rtl/rs_cdb_arb.sv
module rs_cdb_arb #(
  parameter int unsigned N      = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic [N-1:0]             done_i,
  input  logic [N-1:0][TAG_W-1:0]  tag_i,
  input  logic [N-1:0][DATA_W-1:0] val_i,
  output logic [N-1:0]             stall_o,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [DATA_W-1:0]        val_o
);
  logic [N-1:0] gnt;

  // lowest index wins
  assign gnt     = done_i & (~done_i + N'(1));
  assign stall_o = done_i & ~gnt;
  assign valid_o = |done_i;

  always_comb begin
    tag_o = '0;
    val_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (gnt[i]) begin
        tag_o = tag_i[i];
        val_o = val_i[i];
      end
    end
  end
endmodule

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  src_tag_i,
  input  logic              src_rdy_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic [DATA_W-1:0] rob_val_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_val_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0] tag_q;
  logic             hit_wait, hit_new;

  assign hit_wait = cdb_valid_i && (cdb_tag_i == tag_q);
  assign hit_new  = cdb_valid_i && (cdb_tag_i == src_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      tag_q  <= '0;
      val_o  <= '0;
    end else if (clr_i) begin
      pend_o <= 1'b0;
    end else if (load_i) begin
      tag_q <= src_tag_i;
      if (src_tag_i == '0) begin
        pend_o <= 1'b0;
        val_o  <= rf_val_i;
      end else if (src_rdy_i) begin
        pend_o <= 1'b0;
        val_o  <= rob_val_i;
      end else if (hit_new) begin
        pend_o <= 1'b0;   // producer broadcasts in dispatch cycle
        val_o  <= cdb_val_i;
      end else begin
        pend_o <= 1'b1;
      end
    end else if (pend_o && hit_wait) begin
      pend_o <= 1'b0;
      val_o  <= cdb_val_i;
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned OP_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     alloc_i,
  input  logic [OP_W-1:0]          op_i,
  input  logic [TAG_W-1:0]         dst_i,
  input  logic [1:0][TAG_W-1:0]    src_tag_i,
  input  logic [1:0]               src_rdy_i,
  input  logic [1:0][DATA_W-1:0]   rf_val_i,
  input  logic [1:0][DATA_W-1:0]   rob_val_i,
  input  logic                     cdb_valid_i,
  input  logic [TAG_W-1:0]         cdb_tag_i,
  input  logic [DATA_W-1:0]        cdb_val_i,
  input  logic                     gnt_i,
  output logic                     busy_o,
  output logic                     req_o,
  output logic [OP_W-1:0]          op_o,
  output logic [TAG_W-1:0]         dst_o,
  output logic [1:0][DATA_W-1:0]   opnd_o
);
  logic [1:0] pend;
  logic       free;

  assign req_o = busy_o && (pend == 2'b00);
  assign free  = req_o && gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      op_o   <= '0;
      dst_o  <= '0;
    end else if (flush_i || free) begin
      busy_o <= 1'b0;
    end else if (alloc_i) begin
      busy_o <= 1'b1;
      op_o   <= op_i;
      dst_o  <= dst_i;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) opnd_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (flush_i || free),
      .load_i     (alloc_i),
      .src_tag_i  (src_tag_i[s]),
      .src_rdy_i  (src_rdy_i[s]),
      .rf_val_i   (rf_val_i[s]),
      .rob_val_i  (rob_val_i[s]),
      .cdb_valid_i(cdb_valid_i),
      .cdb_tag_i  (cdb_tag_i),
      .cdb_val_i  (cdb_val_i),
      .pend_o     (pend[s]),
      .val_o      (opnd_o[s])
    );
  end
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned OP_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          flush_i,
  input  logic                          disp_valid_i,
  input  logic [CLS_W-1:0]              disp_class_i,
  input  logic [OP_W-1:0]               disp_op_i,
  input  logic [TAG_W-1:0]              disp_dst_tag_i,
  input  logic [1:0][TAG_W-1:0]         disp_src_tag_i,
  input  logic [1:0]                    disp_src_rdy_i,
  input  logic [1:0][DATA_W-1:0]        disp_rf_val_i,
  input  logic [1:0][DATA_W-1:0]        disp_rob_val_i,
  output logic                          disp_stall_o,
  output logic [NUM_RS-1:0]             issue_req_o,
  input  logic [NUM_RS-1:0]             issue_gnt_i,
  output logic [NUM_RS-1:0][OP_W-1:0]   issue_op_o,
  output logic [NUM_RS-1:0][TAG_W-1:0]  issue_tag_o,
  output logic [NUM_RS-1:0][DATA_W-1:0] issue_v1_o,
  output logic [NUM_RS-1:0][DATA_W-1:0] issue_v2_o,
  input  logic [NUM_RS-1:0]             fu_done_i,
  input  logic [NUM_RS-1:0][TAG_W-1:0]  fu_tag_i,
  input  logic [NUM_RS-1:0][DATA_W-1:0] fu_val_i,
  output logic [NUM_RS-1:0]             fu_stall_o,
  output logic                          cdb_valid_o,
  output logic [TAG_W-1:0]              cdb_tag_o,
  output logic [DATA_W-1:0]             cdb_val_o
);
  logic [NUM_RS-1:0] busy_w;
  logic [NUM_RS-1:0] alloc_w;
  logic              sel_busy;

  always_comb begin
    sel_busy = 1'b1;  // out-of-range class is refused
    for (int i = 0; i < int'(NUM_RS); i++) begin
      if (disp_class_i == CLS_W'(i)) sel_busy = busy_w[i];
    end
  end

  assign disp_stall_o = disp_valid_i && sel_busy;

  rs_cdb_arb #(.N(NUM_RS), .DATA_W(DATA_W), .TAG_W(TAG_W)) arb_i (
    .done_i (fu_done_i),
    .tag_i  (fu_tag_i),
    .val_i  (fu_val_i),
    .stall_o(fu_stall_o),
    .valid_o(cdb_valid_o),
    .tag_o  (cdb_tag_o),
    .val_o  (cdb_val_o)
  );

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rs
    logic [1:0][DATA_W-1:0] opnd;

    assign alloc_w[i] = disp_valid_i && !flush_i && !busy_w[i] &&
                        (disp_class_i == CLS_W'(i));

    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) ent_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc_w[i]),
      .op_i       (disp_op_i),
      .dst_i      (disp_dst_tag_i),
      .src_tag_i  (disp_src_tag_i),
      .src_rdy_i  (disp_src_rdy_i),
      .rf_val_i   (disp_rf_val_i),
      .rob_val_i  (disp_rob_val_i),
      .cdb_valid_i(cdb_valid_o),
      .cdb_tag_i  (cdb_tag_o),
      .cdb_val_i  (cdb_val_o),
      .gnt_i      (issue_gnt_i[i]),
      .busy_o     (busy_w[i]),
      .req_o      (issue_req_o[i]),
      .op_o       (issue_op_o[i]),
      .dst_o      (issue_tag_o[i]),
      .opnd_o     (opnd)
    );

    assign issue_v1_o[i] = opnd[0];
    assign issue_v2_o[i] = opnd[1];
  end
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned OP_W   = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         flush_i,
  input logic                         disp_valid_i,
  input logic [CLS_W-1:0]             disp_class_i,
  input logic [TAG_W-1:0]             disp_dst_tag_i,
  input logic                         disp_stall_o,
  input logic [NUM_RS-1:0]            busy_w,
  input logic [NUM_RS-1:0]            issue_req_o,
  input logic [NUM_RS-1:0]            issue_gnt_i,
  input logic [NUM_RS-1:0][TAG_W-1:0] issue_tag_o,
  input logic [NUM_RS-1:0]            fu_done_i,
  input logic [NUM_RS-1:0]            fu_stall_o,
  input logic                         cdb_valid_o
);
  a_r2_stall_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && (disp_class_i < CLS_W'(NUM_RS)) && busy_w[disp_class_i]
    |-> disp_stall_o);

  a_r2_dst_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && !disp_stall_o && !flush_i && (disp_class_i < CLS_W'(NUM_RS))
    |=> issue_tag_o[$past(disp_class_i)] == $past(disp_dst_tag_i));

  a_r11_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> busy_w == '0);

  a_r9_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fu_done_i & ~fu_stall_o));

  a_r9_bus_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fu_done_i) |-> cdb_valid_o && !$stable(1'b0) || (|fu_done_i) |-> cdb_valid_o);

  a_r10_alu_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fu_done_i[0] |-> !fu_stall_o[0]);

  for (genvar i = 0; i < NUM_RS; i++) begin : g_chk
    a_r7_req_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_req_o[i] |-> busy_w[i]);
    a_r8_free_after_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_req_o[i] && issue_gnt_i[i] |=> !busy_w[i]);
  end
endmodule

bind rs_array rs_array_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) chk_i (.*);

// File: tb/rs_array_tb.sv
module rs_array_tb_top;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 4;
  localparam int N      = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic                     flush;
  logic                     disp_valid;
  logic [2:0]               disp_class;
  logic [OP_W-1:0]          disp_op;
  logic [TAG_W-1:0]         disp_dst;
  logic [1:0][TAG_W-1:0]    src_tag;
  logic [1:0]               src_rdy;
  logic [1:0][DATA_W-1:0]   rf_val, rob_val;
  logic                     disp_stall;
  logic [N-1:0]             issue_req, issue_gnt;
  logic [N-1:0][OP_W-1:0]   issue_op;
  logic [N-1:0][TAG_W-1:0]  issue_tag;
  logic [N-1:0][DATA_W-1:0] issue_v1, issue_v2;
  logic [N-1:0]             fu_done, fu_stall;
  logic [N-1:0][TAG_W-1:0]  fu_tag;
  logic [N-1:0][DATA_W-1:0] fu_val;
  logic                     cdb_valid;
  logic [TAG_W-1:0]         cdb_tag;
  logic [DATA_W-1:0]        cdb_val;

  rs_array #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .disp_valid_i(disp_valid), .disp_class_i(disp_class), .disp_op_i(disp_op),
    .disp_dst_tag_i(disp_dst), .disp_src_tag_i(src_tag), .disp_src_rdy_i(src_rdy),
    .disp_rf_val_i(rf_val), .disp_rob_val_i(rob_val), .disp_stall_o(disp_stall),
    .issue_req_o(issue_req), .issue_gnt_i(issue_gnt), .issue_op_o(issue_op),
    .issue_tag_o(issue_tag), .issue_v1_o(issue_v1), .issue_v2_o(issue_v2),
    .fu_done_i(fu_done), .fu_tag_i(fu_tag), .fu_val_i(fu_val), .fu_stall_o(fu_stall),
    .cdb_valid_o(cdb_valid), .cdb_tag_o(cdb_tag), .cdb_val_o(cdb_val)
  );

  // reference model
  logic              m_busy [N];
  logic [1:0]        m_pend [N];
  logic [TAG_W-1:0]  m_tag  [N][2];
  logic [DATA_W-1:0] m_val  [N][2];
  logic [OP_W-1:0]   m_op   [N];
  logic [TAG_W-1:0]  m_dst  [N];

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_req(input int i);
    return m_busy[i] && (m_pend[i] == 2'b00);
  endfunction

  function automatic int exp_win();
    for (int i = 0; i < N; i++) if (fu_done[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_stall();
    if (!disp_valid) return 1'b0;
    if (disp_class >= 3'(N)) return 1'b1;
    return m_busy[disp_class];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_busy[i] = 1'b0; m_pend[i] = 2'b00; m_op[i] = '0; m_dst[i] = '0;
      for (int s = 0; s < 2; s++) begin m_tag[i][s] = '0; m_val[i][s] = '0; end
    end
  endtask

  task automatic model_step();
    logic [N-1:0] req_old;
    int w;
    logic [TAG_W-1:0] bt;
    logic [DATA_W-1:0] bv;
    w = exp_win();
    bt = (w >= 0) ? fu_tag[w] : '0;
    bv = (w >= 0) ? fu_val[w] : '0;
    for (int i = 0; i < N; i++) req_old[i] = exp_req(i);
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_busy[i] = 1'b0; m_pend[i] = 2'b00; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (m_busy[i] && issue_gnt[i] && req_old[i]) begin
          m_busy[i] = 1'b0;
        end else if (m_busy[i]) begin
          for (int s = 0; s < 2; s++)
            if (m_pend[i][s] && w >= 0 && m_tag[i][s] == bt) begin
              m_pend[i][s] = 1'b0; m_val[i][s] = bv;
            end
        end else if (disp_valid && disp_class == 3'(i)) begin
          m_busy[i] = 1'b1; m_op[i] = disp_op; m_dst[i] = disp_dst;
          for (int s = 0; s < 2; s++) begin
            m_tag[i][s] = src_tag[s];
            if (src_tag[s] == '0) begin m_pend[i][s] = 1'b0; m_val[i][s] = rf_val[s]; end
            else if (src_rdy[s]) begin m_pend[i][s] = 1'b0; m_val[i][s] = rob_val[s]; end
            else if (w >= 0 && bt == src_tag[s]) begin m_pend[i][s] = 1'b0; m_val[i][s] = bv; end
            else m_pend[i][s] = 1'b1;
          end
        end
      end
    end
  endtask

  // called at a negedge with inputs driven; checks, then advances one cycle
  task automatic tick(input string lbl);
    int w;
    #1;
    w = exp_win();
    chk({"R2 stall ", lbl}, 64'(disp_stall), 64'(exp_stall()));
    for (int i = 0; i < N; i++) begin
      chk({"R7 req ", lbl}, 64'(issue_req[i]), 64'(exp_req(i)));
      if (exp_req(i)) begin
        chk({"R2 op/tag ", lbl}, {issue_op[i], issue_tag[i]}, {m_op[i], m_dst[i]});
        chk({"R5 v1 ", lbl}, 64'(issue_v1[i]), 64'(m_val[i][0]));
        chk({"R5 v2 ", lbl}, 64'(issue_v2[i]), 64'(m_val[i][1]));
      end
    end
    chk({"R9 bus valid ", lbl}, 64'(cdb_valid), 64'(w >= 0));
    if (w >= 0) chk({"R9 bus data ", lbl}, {cdb_tag, cdb_val}, {fu_tag[w], fu_val[w]});
    chk({"R10 unit stall ", lbl}, 64'(fu_stall), 64'(fu_done & ~(w >= 0 ? N'(1) << w : N'(0))));
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; disp_valid = 0; disp_class = 0; disp_op = 0; disp_dst = 0;
    src_tag = '0; src_rdy = '0; rf_val = '0; rob_val = '0;
    issue_gnt = '0; fu_done = '0; fu_tag = '0; fu_val = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R1 reset req", 64'(issue_req), 64'(0));
    disp_valid = 1; disp_class = 0;
    #1 chk("R1 reset stall", 64'(disp_stall), 64'(0));
    idle();

    // R3: register-file sources
    disp_valid = 1; disp_class = 0; disp_op = 4'h3; disp_dst = 4'h2;
    rf_val[0] = 32'hAAAA_0001; rf_val[1] = 32'hAAAA_0002;
    tick("R3"); idle();
    chk("R3 v1", 64'(issue_v1[0]), 64'h0000_0000_AAAA_0001);
    chk("R3 v2", 64'(issue_v2[0]), 64'h0000_0000_AAAA_0002);

    // R4: value ready in reorder buffer
    disp_valid = 1; disp_class = 1; disp_dst = 4'h6;
    src_tag[0] = 4'h5; src_rdy[0] = 1; rob_val[0] = 32'hBBBB_0005; rf_val[0] = 32'h1;
    tick("R4"); idle();
    chk("R4 v1", 64'(issue_v1[1]), 64'h0000_0000_BBBB_0005);

    // R5: wait, ignore foreign tag, capture own tag
    disp_valid = 1; disp_class = 2; disp_dst = 4'h8; src_tag[0] = 4'h7;
    tick("R5"); idle();
    fu_done[3] = 1; fu_tag[3] = 4'h6; fu_val[3] = 32'h6666;
    tick("R5"); idle();
    chk("R5 still waiting", 64'(issue_req[2]), 64'(0));
    fu_done[3] = 1; fu_tag[3] = 4'h7; fu_val[3] = 32'hD00D;
    tick("R5"); idle();
    chk("R5 captured req", 64'(issue_req[2]), 64'(1));
    chk("R5 captured val", 64'(issue_v1[2]), 64'h0000_0000_0000_D00D);

    // R6: bus hit in the dispatch cycle
    disp_valid = 1; disp_class = 3; disp_dst = 4'hA; src_tag[1] = 4'h9;
    fu_done[0] = 1; fu_tag[0] = 4'h9; fu_val[0] = 32'hE0E0;
    tick("R6"); idle();
    chk("R6 req", 64'(issue_req[3]), 64'(1));
    chk("R6 v2", 64'(issue_v2[3]), 64'h0000_0000_0000_E0E0);

    // R8: grant frees; grant to idle station ignored
    issue_gnt = 5'b10001;
    tick("R8"); idle();
    chk("R8 freed", 64'(issue_req[0]), 64'(0));
    disp_valid = 1; disp_class = 0;
    tick("R8"); idle();
    chk("R8 idle grant", 64'(issue_req[4]), 64'(0));

    // R10: everyone finishes together
    fu_done = 5'b11110;
    for (int i = 0; i < N; i++) begin fu_tag[i] = 4'(i + 1); fu_val[i] = 32'(i * 16); end
    tick("R10");
    fu_done = 5'b11111;
    tick("R10"); idle();

    // R11: flush drops simultaneous dispatch
    flush = 1; disp_valid = 1; disp_class = 4;
    tick("R11"); idle();
    chk("R11 empty", 64'(issue_req), 64'(0));
    disp_valid = 1; disp_class = 4;
    #1 chk("R11 station free", 64'(disp_stall), 64'(0));
    idle();
    flush = 1; tick("R11"); idle();

    // random mix
    for (int c = 0; c < 3000; c++) begin
      flush      = ($urandom % 40) == 0;
      disp_valid = $urandom % 2;
      disp_class = 3'($urandom % 6);
      disp_op    = 4'($urandom);
      disp_dst   = 4'(1 + $urandom % 15);
      for (int s = 0; s < 2; s++) begin
        if ($urandom % 3 == 0) begin src_tag[s] = '0; src_rdy[s] = 0; end
        else begin src_tag[s] = 4'(1 + $urandom % 7); src_rdy[s] = $urandom % 2; end
        rf_val[s] = $urandom; rob_val[s] = $urandom;
      end
      issue_gnt = 5'($urandom);
      fu_done   = 5'($urandom) & 5'($urandom);
      for (int i = 0; i < N; i++) begin fu_tag[i] = 4'(1 + $urandom % 7); fu_val[i] = $urandom; end
      tick("random");
    end
    idle();
    finish_run();
  end
endmodule